// File: doc/BRIEF.md
# Clock Frequency Meter

This block compares how often a monitored clock toggles against the block's own reference clock. Software programs a measurement window, given as a number of reference cycles, and picks one of four monitored channels. It then sets the detect-enable bit. From that point the meter counts the reference cycles and, alongside them, the monitored edges on the chosen channel. When the window has elapsed, the meter stores the edge count in a read-only result register and raises a valid flag. Software reads the result and then clears the enable.

Each monitored clock arrives as a synchronous one-cycle tick per edge, already in the reference domain. The block does no clock-domain crossing. Counting only runs while a free-run gate bit in the status register is also set. Clearing that bit pauses a measurement without losing its progress.

All access goes through a plain 32-bit register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. The port has no flow control, so every access completes in one cycle.

Top module: `freqm_top`

## Requirements
- R1: After reset, the control register, result register and status register all read zero.
- R2: The control register sits at byte offset 0x00. Bits 23:0 hold the window length, bit 24 is detect-enable and bits 27:26 select the channel. All other bits read zero whatever was written.
- R3: The status register sits at offset 0x10. Bit 0 is the valid flag and is read-only. Bit 8 is the free-run gate and is read/write. Its other bits read zero. The result register at offset 0x0C is read-only and its upper 8 bits read zero.
- R4: The counters are zero while detect-enable is low, so a measurement starts when the enable goes high. The first counted cycle is the first cycle after the write that sets the enable. After W counted cycles, the result equals the number of ticks seen on the selected channel during those cycles. The valid flag rises on the clock edge that ends the last counted cycle.
- R5: Only ticks on the channel selected by bits 27:26 add to the count. Ticks on the other channels have no effect on the result.
- R6: The valid flag stays low until the window completes. Once it is set and detect-enable stays high, counting stops and both the result and the valid flag hold.
- R7: Clearing detect-enable clears the valid flag on the next edge and resets the counters. The result register keeps its last value.
- R8: While the free-run gate is low, neither reference cycles nor ticks are counted. Setting the gate again resumes the same measurement.
- R9: A window length of zero never completes, and the valid flag stays low.
- R10: Writes to offsets other than 0x00 and 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 5 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mon_tick | input | 4 | One tick per monitored edge, one bit per channel |

## Verification
The measurement is run with several windows and bit patterns. On the selected channel the pattern is one sequence and on every other channel it is the exact complement, so a wrong channel decode yields W minus the expected count instead of the expected count. An all-ones pattern shows whether the first and last cycles of the window are both counted. A window that is paused by the free-run gate, with ticks fed during the pause, shows whether the gate stops the edge counter as well as the reference counter. A zero window, the hold after completion and a re-run after clearing the enable cover the corners of the start and stop behaviour.

// File: rtl/freqm_pkg.sv
package freqm_pkg;
  localparam int DATA_W   = 32;
  localparam int WIN_W    = 24;
  localparam int NCH      = 4;
  localparam int SEL_W    = $clog2(NCH);

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_RESULT = 'h0C;
  localparam int OFF_STATUS = 'h10;

  localparam int BIT_ENABLE = 24;
  localparam int CHAN_LSB   = 26;
  localparam int BIT_VALID  = 0;
  localparam int BIT_GATE   = 8;
endpackage

// File: rtl/freqm_regfile.sv
module freqm_regfile
  import freqm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              valid,
  input  logic [WIN_W-1:0]  result,
  output logic [DATA_W-1:0] rdata,
  output logic [WIN_W-1:0]  window,
  output logic              det_en,
  output logic [SEL_W-1:0]  chan,
  output logic              gate_en
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_RESULT = ADDR_W'(OFF_RESULT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic hit_ctrl, hit_result, hit_status;
  assign hit_ctrl   = (addr == A_CTRL);
  assign hit_result = (addr == A_RESULT);
  assign hit_status = (addr == A_STATUS);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:CHAN_LSB+SEL_W], wdata[BIT_ENABLE+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window  <= '0;
      det_en  <= 1'b0;
      chan    <= '0;
      gate_en <= 1'b0;
    end else if (wr) begin
      if (hit_ctrl) begin
        window <= wdata[WIN_W-1:0];
        det_en <= wdata[BIT_ENABLE];
        chan   <= wdata[CHAN_LSB +: SEL_W];
      end
      if (hit_status) begin
        gate_en <= wdata[BIT_GATE];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl) begin
      rdata[WIN_W-1:0]          = window;
      rdata[BIT_ENABLE]         = det_en;
      rdata[CHAN_LSB +: SEL_W]  = chan;
    end else if (hit_result) begin
      rdata[WIN_W-1:0]          = result;
    end else if (hit_status) begin
      rdata[BIT_VALID]          = valid;
      rdata[BIT_GATE]           = gate_en;
    end
  end
endmodule

// File: rtl/freqm_chan_sel.sv
module freqm_chan_sel #(
  parameter int N_CH  = 4,
  parameter int SEL_B = 2
) (
  input  logic [N_CH-1:0]  ticks,
  input  logic [SEL_B-1:0] sel,
  output logic             tick
);
  logic [N_CH-1:0] hit;
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign hit[i] = ticks[i] & (sel == SEL_B'(i));
  end
  assign tick = |hit;
endmodule

// File: rtl/freqm_window_ctr.sv
module freqm_window_ctr #(
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_en,
  input  logic          gate_en,
  input  logic [WW-1:0] window,
  input  logic          tick,
  output logic          valid,
  output logic [WW-1:0] result,
  output logic [WW-1:0] ref_cnt
);
  logic [WW-1:0] edge_cnt;
  logic          active;
  logic          last;
  logic [WW:0]   ref_next;

  assign active   = det_en & gate_en & ~valid & (window != '0);
  assign ref_next = {1'b0, ref_cnt} + (WW+1)'(1);
  assign last     = (ref_next >= {1'b0, window});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      edge_cnt <= '0;
      valid    <= 1'b0;
      result   <= '0;
    end else if (!det_en) begin
      ref_cnt  <= '0;
      edge_cnt <= '0;
      valid    <= 1'b0;
    end else if (active) begin
      ref_cnt  <= ref_next[WW-1:0];
      edge_cnt <= edge_cnt + WW'(tick);
      if (last) begin
        valid  <= 1'b1;
        result <= edge_cnt + WW'(tick);
      end
    end
  end
endmodule

// File: rtl/freqm_top.sv
module freqm_top
  import freqm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        mon_tick
);
  logic [WIN_W-1:0] window;
  logic             det_en;
  logic [SEL_W-1:0] chan;
  logic             gate_en;
  logic             valid;
  logic [WIN_W-1:0] result;
  logic [WIN_W-1:0] ref_cnt;
  logic             tick;

  freqm_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .valid(valid), .result(result), .rdata(reg_rdata),
    .window(window), .det_en(det_en), .chan(chan), .gate_en(gate_en)
  );

  freqm_chan_sel #(.N_CH(NCH), .SEL_B(SEL_W)) u_sel (
    .ticks(mon_tick), .sel(chan), .tick(tick)
  );

  freqm_window_ctr #(.WW(WIN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .gate_en(gate_en),
    .window(window), .tick(tick), .valid(valid), .result(result),
    .ref_cnt(ref_cnt)
  );
endmodule

// File: rtl/freqm_checker.sv
module freqm_checker #(
  parameter int WW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          det_en,
  input logic          gate_en,
  input logic [WW-1:0] window,
  input logic          valid,
  input logic [WW-1:0] result,
  input logic [WW-1:0] ref_cnt
);
  a_r4_valid_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(det_en) && $past(gate_en)));

  a_r6_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && det_en) |=> (valid && $stable(result)));

  a_r7_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (!valid && ref_cnt == '0 && $stable(result)));

  a_r8_gate_pauses: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && det_en) |=> ($stable(ref_cnt) && $stable(valid)));

  a_r9_zero_window: assert property (@(posedge clk) disable iff (!rst_n)
    (window == '0 && !valid) |=> !valid);
endmodule

bind freqm_top freqm_checker #(.WW(freqm_pkg::WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .gate_en(gate_en),
  .window(window), .valid(valid), .result(result), .ref_cnt(ref_cnt)
);

// File: tb/freqm_top_test.sv
module freqm_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  mon_tick = '0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  freqm_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_tick(mon_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int ch, input int w, input bit en);
    return (32'(ch) << 26) | (32'(en) << 24) | (32'(w) & 32'hFF_FFFF);
  endfunction

  // Drive W cycles: selected channel gets pat, others get its complement.
  task automatic drive(input int ch, input int w, input logic [63:0] pat, input bit chk_pending);
    logic [31:0] d;
    for (int k = 0; k < w; k++) begin
      for (int c = 0; c < 4; c++) mon_tick[c] = (c == ch) ? pat[k] : ~pat[k];
      if (chk_pending && k == w-1) begin
        rd(5'h10, d);
        chk("R6 valid low before last cycle", {31'b0, d[0]}, 32'h0);
      end
      @(negedge clk);
    end
    mon_tick = '0;
  endtask

  // Driver: starts a measurement and pushes the expected result.
  task automatic measure(input int ch, input int w, input logic [63:0] pat);
    int n = 0;
    for (int k = 0; k < w; k++) n += int'(pat[k]);
    exp_q.push_back(n);
    wr(5'h00, ctrl_word(ch, w, 1'b1));
    drive(ch, w, pat, 1'b1);
  endtask

  // Monitor side of the scoreboard: pops and compares against the bus.
  task automatic score(input string req);
    logic [31:0] d;
    int e;
    e = exp_q.pop_front();
    rd(5'h10, d);
    chk({req, " valid set"}, {31'b0, d[0]}, 32'h1);
    rd(5'h0C, d);
    chk(req, d, 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'h00, d); chk("R1 ctrl reset", d, 32'h0);
    rd(5'h0C, d); chk("R1 result reset", d, 32'h0);
    rd(5'h10, d); chk("R1 status reset", d, 32'h0);

    // R3 status: valid read-only, gate read/write
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d); chk("R3 status write mask", d, 32'h100);

    // R4/R5 measurement on channel 0 and channel 2
    measure(0, 8, 64'hA5);
    score("R4 ch0 count");
    wr(5'h00, 32'h0);
    measure(2, 10, 64'h3B1);
    score("R5 ch2 count");
    wr(5'h00, 32'h0);
    measure(3, 5, 64'h1F);
    score("R4 all-ones window");

    // R6 hold after completion while enable stays high
    drive(3, 6, 64'h3F, 1'b0);
    rd(5'h0C, d); chk("R6 result held", d, 32'd5);
    rd(5'h10, d); chk("R6 valid held", d, 32'h101);

    // R7 disable: valid drops, result kept
    wr(5'h00, 32'h0);
    @(negedge clk);
    rd(5'h10, d); chk("R7 valid cleared", d, 32'h100);
    rd(5'h0C, d); chk("R7 result kept", d, 32'd5);

    // R2 field layout and reserved bits (enable left low)
    wr(5'h00, 32'hF6AB_CDEF);
    rd(5'h00, d); chk("R2 ctrl fields", d, 32'h04AB_CDEF);
    wr(5'h00, 32'h0);

    // R10 unmapped and read-only writes ignored
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h1234_5678);
    rd(5'h00, d); chk("R10 ctrl untouched", d, 32'h0);
    rd(5'h0C, d); chk("R10 result untouched", d, 32'd5);
    rd(5'h10, d); chk("R10 status untouched", d, 32'h100);

    // R8 gate low pauses the measurement
    wr(5'h10, 32'h0);
    wr(5'h00, ctrl_word(1, 6, 1'b1));
    drive(1, 6, 64'h3F, 1'b0);
    rd(5'h10, d); chk("R8 no completion while gated", d, 32'h0);
    exp_q.push_back(4);
    wr(5'h10, 32'h100);
    drive(1, 6, 64'h2D, 1'b1);
    score("R8 resumed count");
    wr(5'h00, 32'h0);

    // R9 zero window never completes
    wr(5'h00, ctrl_word(0, 0, 1'b1));
    drive(0, 40, 64'hFFFF_FFFF_FF, 1'b0);
    rd(5'h10, d); chk("R9 zero window no valid", d, 32'h100);
    rd(5'h0C, d); chk("R9 result unchanged", d, 32'd4);
    wr(5'h00, 32'h0);

    // R7 restart starts from cleared counters
    measure(1, 12, 64'h00F);
    score("R7 restart count");
    wr(5'h00, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule